// File: doc/BRIEF.md
# Cross-Unit Forwarding Start-Time Scoreboard

This block works out when each micro-op can begin and end. It reads micro-ops one per clock, in program order. For each one it looks up when the source registers become ready and which kind of unit produces them. It adds a forwarding penalty that depends on the producer unit class and the consumer unit class. It rounds the start up to a whole clock when the consumer runs at single speed. It then waits for the target unit to be free. All times are unsigned counts of half-cycles.

There are four unit classes. Two double-speed ALU lanes can start on any half-cycle. An integer unit and a floating-point unit run at single speed, and so does a move unit. The scoreboard keeps two kinds of state. For every architectural register it holds a ready time and the class that produced the value. For every unit it holds the time at which that unit is next free.

A performance model or an issue stage can feed the block a stream of micro-ops. It reads back the schedule a cycle later and needs no other handshake.

Top module: `bypass_sched`

## Requirements
- R1: After reset, every register is ready at time 0 and counts as produced by the move unit, so it carries no penalty. Every unit is free at time 0. `res_vld` is low while reset is asserted.
- R2: A micro-op presented with `issue_vld` high gives `res_vld` high on the next cycle. `res_finish` then equals `res_start` plus the micro-op's latency. When no micro-op is issued, `res_vld` is low on the next cycle.
- R3: Unit class codes on `issue_cls` are: 0 = double-speed ALU, 1 = integer unit, 2 = floating-point unit, 3 = move unit. No penalty is added when producer and consumer are in the same class.
- R4: When a value passes from the integer unit or the floating-point unit to a different class, 2 half-cycles (one clock) are added.
- R5: When a value passes from a double-speed ALU to any class other than the double-speed ALU, 1 half-cycle is added.
- R6: A value produced by the move unit reaches any consumer class with no penalty.
- R7: The integer, floating-point and move units start only on even half-cycle counts. A candidate odd start is rounded up by one.
- R8: A micro-op never starts before its target unit is free. A unit becomes free again at its previous start plus that micro-op's occupancy.
- R9: A double-speed ALU micro-op goes to the lane that gives the earlier start, and lane 0 wins a tie. The lane used is reported on `res_lane`. `res_lane` is 0 for micro-ops in the other classes.
- R10: A source whose valid flag is low plays no part in the start time. A destination that is also a source is read with its value from before this micro-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | 1 | A micro-op is presented this cycle |
| issue_dst | input | 3 | Destination register index |
| issue_src0 | input | 3 | First source register index |
| issue_src0_vld | input | 1 | First source is used |
| issue_src1 | input | 3 | Second source register index |
| issue_src1_vld | input | 1 | Second source is used |
| issue_cls | input | 2 | Target unit class (see R3) |
| issue_lat | input | 6 | Latency in half-cycles |
| issue_occ | input | 6 | Unit occupancy in half-cycles (at least 1) |
| res_vld | output | 1 | Schedule result valid |
| res_start | output | 16 | Start time in half-cycles |
| res_finish | output | 16 | Finish time in half-cycles |
| res_lane | output | 1 | Double-speed ALU lane used |

## Verification
Each schedule result is registered once, so it is due exactly one clock after the micro-op is presented. The register and unit state it updates takes effect in time for a micro-op issued on the very next cycle. The bench drives each micro-op on a falling edge and checks the result on the following falling edge, after the single capturing rising edge. The next micro-op is driven in that same slot, so dependent micro-ops run back to back. After a mid-run reset, the first check falls one clock after the release, and it shows that all the old state has been cleared.

// File: rtl/bsched_pkg.sv
// Package: unit class encoding and the producer/consumer forwarding penalty.
// Assumes times are unsigned half-cycle counts.
package bsched_pkg;

    typedef enum logic [1:0] {
        UC_FAST = 2'd0,
        UC_INT  = 2'd1,
        UC_FP   = 2'd2,
        UC_MOVE = 2'd3
    } ucls_e;

    // Extra half-cycles for passing a value from producer class p to consumer class c
    function automatic logic [1:0] fwd_pen(input ucls_e p, input ucls_e c);
        logic [1:0] r;
        if (p == UC_MOVE)      r = 2'd0;
        else if (p == UC_FAST) r = (c == UC_FAST) ? 2'd0 : 2'd1;
        else                   r = (p == c) ? 2'd0 : 2'd2;
        return r;
    endfunction

endpackage

// File: rtl/bsched_regs.sv
// Register ready-time table. Each entry holds the half-cycle at which the
// register value is ready and the class of the unit that produced it.
// Two combinational read ports, one synchronous write port. Reads see the
// contents from before a same-cycle write.
module bsched_regs
    import bsched_pkg::*;
#(
    parameter int NREG = 8,
    parameter int TW   = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rd0_addr,
    output logic [TW-1:0] rd0_time,
    output ucls_e         rd0_cls,
    input  logic [RW-1:0] rd1_addr,
    output logic [TW-1:0] rd1_time,
    output ucls_e         rd1_cls,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_addr,
    input  logic [TW-1:0] wr_time,
    input  ucls_e         wr_cls
);

    logic [TW-1:0] rdy_q [NREG];
    ucls_e         cls_q [NREG];

    // Read both source entries
    always_comb begin
        rd0_time = rdy_q[rd0_addr];
        rd0_cls  = cls_q[rd0_addr];
        rd1_time = rdy_q[rd1_addr];
        rd1_cls  = cls_q[rd1_addr];
    end

    genvar g;
    for (g = 0; g < NREG; g++) begin : g_ent
        // Clear on reset, else capture the new ready time when this entry is written
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdy_q[g] <= '0;
                cls_q[g] <= UC_MOVE;
            end else if (wr_en && (wr_addr == RW'(g))) begin
                rdy_q[g] <= wr_time;
                cls_q[g] <= wr_cls;
            end
        end
    end

endmodule

// File: rtl/bsched_fwd.sv
// Operand readiness stage. Adds the class-pair forwarding penalty to each
// valid source's ready time, takes the later of the two, and rounds up to an
// even half-cycle for single-speed consumers. With no valid source the result is 0.
module bsched_fwd
    import bsched_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chk_en,
    input  logic          s0_vld,
    input  logic [TW-1:0] s0_time,
    input  ucls_e         s0_cls,
    input  logic          s1_vld,
    input  logic [TW-1:0] s1_time,
    input  ucls_e         s1_cls,
    input  ucls_e         c_cls,
    output logic [TW-1:0] dep_time
);

    logic [TW-1:0] arr0, arr1, late;

    // Operand arrival times including penalty; unused sources count as time 0
    always_comb begin
        arr0 = s0_vld ? (s0_time + TW'(fwd_pen(s0_cls, c_cls))) : '0;
        arr1 = s1_vld ? (s1_time + TW'(fwd_pen(s1_cls, c_cls))) : '0;
        late = (arr0 > arr1) ? arr0 : arr1;
    end

    // Single-speed consumers round up to a whole clock
    always_comb begin
        if (c_cls != UC_FAST) dep_time = late + TW'(late[0]);
        else                  dep_time = late;
    end

    // R10
    // dep_src0_chk: a valid first source never arrives after the computed time
    dep_src0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && s0_vld) |-> (dep_time >= s0_time));

    // R10
    // dep_src1_chk: a valid second source never arrives after the computed time
    dep_src1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && s1_vld) |-> (dep_time >= s1_time));

endmodule

// File: rtl/bsched_units.sv
// Unit vacancy tracker. Holds the next-free time of each double-speed lane
// and each single-speed unit. Picks the earliest-starting fast lane (lane 0
// on a tie), rounds single-speed starts up to even, and marks the unit busy
// for the micro-op's occupancy.
module bsched_units
    import bsched_pkg::*;
#(
    parameter int TW    = 16,
    parameter int OW    = 6,
    parameter int NFAST = 2,
    localparam int LW   = (NFAST > 1) ? $clog2(NFAST) : 1,
    localparam int NU   = NFAST + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_vld,
    input  ucls_e         iss_cls,
    input  logic [TW-1:0] dep_time,
    input  logic [OW-1:0] iss_occ,
    output logic [TW-1:0] start_time,
    output logic [LW-1:0] lane_sel
);

    logic [TW-1:0] free_q [NU];
    logic [TW-1:0] lane_t [NFAST];
    logic [TW-1:0] best_t, slow_raw, slow_t;
    logic [LW-1:0] best_l;
    int unsigned   slow_idx, upd_idx;

    genvar g;
    for (g = 0; g < NFAST; g++) begin : g_lane
        // Candidate start on this fast lane
        assign lane_t[g] = (dep_time > free_q[g]) ? dep_time : free_q[g];
    end

    // Earliest fast lane; strict compare keeps the lowest index on a tie
    always_comb begin
        best_t = lane_t[0];
        best_l = '0;
        for (int i = 1; i < NFAST; i++) begin
            if (lane_t[i] < best_t) begin
                best_t = lane_t[i];
                best_l = LW'(i);
            end
        end
    end

    // Single-speed candidate, rounded to a whole clock
    always_comb begin
        unique case (iss_cls)
            UC_INT:  slow_idx = NFAST;
            UC_FP:   slow_idx = NFAST + 1;
            default: slow_idx = NFAST + 2;
        endcase
        slow_raw = (dep_time > free_q[slow_idx]) ? dep_time : free_q[slow_idx];
        slow_t   = slow_raw + TW'(slow_raw[0]);
    end

    // Final start time, lane report and the unit to mark busy
    always_comb begin
        if (iss_cls == UC_FAST) begin
            start_time = best_t;
            lane_sel   = best_l;
            upd_idx    = 32'(best_l);
        end else begin
            start_time = slow_t;
            lane_sel   = '0;
            upd_idx    = slow_idx;
        end
    end

    // Clear on reset, else mark the chosen unit busy until start plus occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NU; i++) free_q[i] <= '0;
        end else if (iss_vld) begin
            free_q[upd_idx] <= start_time + TW'(iss_occ);
        end
    end

    // R8
    // vacancy_chk: never start before the chosen unit is free
    vacancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> (start_time >= free_q[upd_idx]));

    // R8
    // dep_wait_chk: never start before the operands arrive
    dep_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> (start_time >= dep_time));

endmodule

// File: rtl/bypass_sched.sv
// Top of the forwarding start-time scoreboard. Takes one micro-op per clock,
// computes its start and finish in half-cycles from register readiness,
// class-pair forwarding penalties and unit vacancy, and registers the result
// for the next cycle. The register and unit state is updated in the same
// edge, so the next micro-op sees it. Assumes occupancy is at least 1.
module bypass_sched
    import bsched_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int TW    = 16,
    parameter int LATW  = 6,
    parameter int NFAST = 2,
    localparam int RW   = $clog2(NREG),
    localparam int LW   = (NFAST > 1) ? $clog2(NFAST) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_vld,
    input  logic [RW-1:0]   issue_dst,
    input  logic [RW-1:0]   issue_src0,
    input  logic            issue_src0_vld,
    input  logic [RW-1:0]   issue_src1,
    input  logic            issue_src1_vld,
    input  logic [1:0]      issue_cls,
    input  logic [LATW-1:0] issue_lat,
    input  logic [LATW-1:0] issue_occ,
    output logic            res_vld,
    output logic [TW-1:0]   res_start,
    output logic [TW-1:0]   res_finish,
    output logic [LW-1:0]   res_lane
);

    ucls_e         cls_c;
    logic [TW-1:0] s0_t, s1_t, dep_t, start_c, fin_c;
    ucls_e         s0_c, s1_c;
    logic [LW-1:0] lane_c;

    assign cls_c = ucls_e'(issue_cls);

    bsched_regs #(.NREG(NREG), .TW(TW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd0_addr (issue_src0),
        .rd0_time (s0_t),
        .rd0_cls  (s0_c),
        .rd1_addr (issue_src1),
        .rd1_time (s1_t),
        .rd1_cls  (s1_c),
        .wr_en    (issue_vld),
        .wr_addr  (issue_dst),
        .wr_time  (fin_c),
        .wr_cls   (cls_c)
    );

    bsched_fwd #(.TW(TW)) u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_en   (issue_vld),
        .s0_vld   (issue_src0_vld),
        .s0_time  (s0_t),
        .s0_cls   (s0_c),
        .s1_vld   (issue_src1_vld),
        .s1_time  (s1_t),
        .s1_cls   (s1_c),
        .c_cls    (cls_c),
        .dep_time (dep_t)
    );

    bsched_units #(.TW(TW), .OW(LATW), .NFAST(NFAST)) u_units (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_vld    (issue_vld),
        .iss_cls    (cls_c),
        .dep_time   (dep_t),
        .iss_occ    (issue_occ),
        .start_time (start_c),
        .lane_sel   (lane_c)
    );

    // Finish time for the result and for the destination entry
    assign fin_c = start_c + TW'(issue_lat);

    // Register the schedule result for the cycle after issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld    <= 1'b0;
            res_start  <= '0;
            res_finish <= '0;
            res_lane   <= '0;
        end else begin
            res_vld <= issue_vld;
            if (issue_vld) begin
                res_start  <= start_c;
                res_finish <= fin_c;
                res_lane   <= lane_c;
            end
        end
    end

    // R2
    // res_follow_chk: a result appears exactly one cycle after each issue
    res_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |=> res_vld);

    // R2
    // res_idle_chk: no result without an issue in the previous cycle
    res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |=> !res_vld);

    // R7
    // slow_even_chk: single-speed starts land on a whole clock
    slow_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_cls != 2'd0) |=> !res_start[0]);

    // R9
    // slow_lane_chk: the lane report is zero for non-ALU classes
    slow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_cls != 2'd0) |=> (res_lane == '0));

endmodule

// File: tb/bypass_sched_tb.sv
module bypass_sched_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    typedef struct packed {
        logic [2:0]  dst;
        logic [2:0]  s0;
        logic        s0v;
        logic [2:0]  s1;
        logic        s1v;
        logic [1:0]  cls;
        logic [5:0]  lat;
        logic [5:0]  occ;
        logic [15:0] st;
        logic [15:0] fin;
        logic        lane;
    } vec_t;

    // cls: 0 fast ALU, 1 integer, 2 floating point, 3 move
    localparam vec_t TBL [NV] = '{
        '{3'd1, 3'd1, 1'b1, 3'd0, 1'b0, 2'd0, 6'd1,  6'd1, 16'd0,  16'd1,  1'b0}, // R1 R9 lane0
        '{3'd2, 3'd2, 1'b1, 3'd0, 1'b0, 2'd0, 6'd1,  6'd1, 16'd0,  16'd1,  1'b1}, // R9 other lane same slot
        '{3'd1, 3'd1, 1'b1, 3'd0, 1'b0, 2'd0, 6'd1,  6'd1, 16'd1,  16'd2,  1'b0}, // R3 fast->fast
        '{3'd1, 3'd1, 1'b1, 3'd0, 1'b0, 2'd1, 6'd8,  6'd2, 16'd4,  16'd12, 1'b0}, // R5 R7 3 -> 4
        '{3'd1, 3'd1, 1'b1, 3'd3, 1'b1, 2'd0, 6'd1,  6'd1, 16'd14, 16'd15, 1'b0}, // R4 int->fast
        '{3'd4, 3'd1, 1'b1, 3'd0, 1'b0, 2'd0, 6'd1,  6'd1, 16'd15, 16'd16, 1'b0}, // R9 tie lane0
        '{3'd4, 3'd4, 1'b1, 3'd0, 1'b0, 2'd2, 6'd14, 6'd2, 16'd18, 16'd32, 1'b0}, // R5 R7 17 -> 18
        '{3'd5, 3'd4, 1'b1, 3'd0, 1'b0, 2'd1, 6'd8,  6'd2, 16'd34, 16'd42, 1'b0}, // R4 fp->int
        '{3'd6, 3'd5, 1'b1, 3'd0, 1'b0, 2'd1, 6'd8,  6'd2, 16'd42, 16'd50, 1'b0}, // R3 int->int
        '{3'd7, 3'd6, 1'b1, 3'd0, 1'b0, 2'd3, 6'd12, 6'd2, 16'd52, 16'd64, 1'b0}, // R4 int->move
        '{3'd0, 3'd7, 1'b1, 3'd0, 1'b0, 2'd0, 6'd1,  6'd1, 16'd64, 16'd65, 1'b0}, // R6 move->fast
        '{3'd3, 3'd7, 1'b1, 3'd0, 1'b0, 2'd1, 6'd8,  6'd2, 16'd64, 16'd72, 1'b0}, // R6 move->int
        '{3'd2, 3'd2, 1'b1, 3'd0, 1'b0, 2'd1, 6'd8,  6'd2, 16'd66, 16'd74, 1'b0}, // R8 int busy
        '{3'd6, 3'd0, 1'b1, 3'd0, 1'b0, 2'd2, 6'd14, 6'd2, 16'd66, 16'd80, 1'b0}, // R5 odd ready 65+1
        '{3'd5, 3'd4, 1'b0, 3'd0, 1'b0, 2'd0, 6'd1,  6'd1, 16'd1,  16'd2,  1'b1}, // R10 no sources
        '{3'd5, 3'd5, 1'b1, 3'd5, 1'b1, 2'd0, 6'd1,  6'd1, 16'd2,  16'd3,  1'b1}, // R10 dst is src
        '{3'd2, 3'd0, 1'b0, 3'd0, 1'b0, 2'd3, 6'd2,  6'd3, 16'd54, 16'd56, 1'b0}, // R8 move busy
        '{3'd3, 3'd0, 1'b0, 3'd0, 1'b0, 2'd3, 6'd2,  6'd1, 16'd58, 16'd60, 1'b0}  // R7 R8 free 57 -> 58
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [2:0]  issue_dst = '0;
    logic [2:0]  issue_src0 = '0;
    logic        issue_src0_vld = 1'b0;
    logic [2:0]  issue_src1 = '0;
    logic        issue_src1_vld = 1'b0;
    logic [1:0]  issue_cls = '0;
    logic [5:0]  issue_lat = '0;
    logic [5:0]  issue_occ = 6'd1;
    logic        res_vld;
    logic [15:0] res_start, res_finish;
    logic [0:0]  res_lane;

    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;

    bypass_sched u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .issue_vld      (issue_vld),
        .issue_dst      (issue_dst),
        .issue_src0     (issue_src0),
        .issue_src0_vld (issue_src0_vld),
        .issue_src1     (issue_src1),
        .issue_src1_vld (issue_src1_vld),
        .issue_cls      (issue_cls),
        .issue_lat      (issue_lat),
        .issue_occ      (issue_occ),
        .res_vld        (res_vld),
        .res_start      (res_start),
        .res_finish     (res_finish),
        .res_lane       (res_lane)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic drive(input vec_t v);
        issue_vld      = 1'b1;
        issue_dst      = v.dst;
        issue_src0     = v.s0;
        issue_src0_vld = v.s0v;
        issue_src1     = v.s1;
        issue_src1_vld = v.s1v;
        issue_cls      = v.cls;
        issue_lat      = v.lat;
        issue_occ      = v.occ;
    endtask

    task automatic check_res(input string req, input logic [15:0] st,
                             input logic [15:0] fin, input logic ln);
        n_chk++;
        if (res_vld !== 1'b1 || res_start !== st || res_finish !== fin || res_lane !== ln) begin
            n_err++;
            $display("FAIL %s: got vld=%0b start=%0d finish=%0d lane=%0d, expected vld=1 start=%0d finish=%0d lane=%0d",
                     req, res_vld, res_start, res_finish, res_lane, st, fin, ln);
        end
    endtask

    task automatic check_idle(input string req);
        n_chk++;
        if (res_vld !== 1'b0) begin
            n_err++;
            $display("FAIL %s: got res_vld=%0b, expected 0", req, res_vld);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after release");

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(negedge clk);
            check_res($sformatf("row %0d R2-R10", i), TBL[i].st, TBL[i].fin, TBL[i].lane);
        end

        // R2: idle cycle gives no result
        issue_vld = 1'b0;
        @(negedge clk);
        check_idle("R2 idle");

        // R1: reset mid-run clears register and unit state
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 mid-run reset");
        rst_n = 1'b1;
        drive('{3'd6, 3'd6, 1'b1, 3'd0, 1'b0, 2'd2, 6'd14, 6'd2, 16'd0, 16'd14, 1'b0});
        @(negedge clk);
        check_res("R1 fp state cleared", 16'd0, 16'd14, 1'b0);
        drive('{3'd4, 3'd3, 1'b1, 3'd2, 1'b1, 2'd0, 6'd1, 6'd1, 16'd0, 16'd1, 1'b0});
        @(negedge clk);
        check_res("R1 fast lanes cleared", 16'd0, 16'd1, 1'b0);
        // R6: register 7 reads as move-produced after reset: int start 0
        drive('{3'd1, 3'd7, 1'b1, 3'd0, 1'b0, 2'd1, 6'd8, 6'd2, 16'd0, 16'd8, 1'b0});
        @(negedge clk);
        check_res("R6 reset class", 16'd0, 16'd8, 1'b0);
        issue_vld = 1'b0;
        @(negedge clk);
        check_idle("R2 final idle");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule